// File: doc/BRIEF.md
# Parallel Printer Output Port

This block drives a Centronics-style printer from three host registers placed in one small port window. The host writes a byte into the data register, which appears on the eight printer data lines. It then writes to the strobe register, which starts an active-low strobe pulse of fixed length. The strobe falls only after the data lines have been steady for one full clock. The host polls a status register to see the printer's busy line, the acknowledge line and whether a strobe sequence is still running.

Both printer inputs pass through two-flop synchronizers. A falling edge on the synchronized acknowledge line counts as one acknowledge event, however long the line stays low. Each event drives all eight data lines to zero, so that no stale byte sits on the cable while the printer finishes. The event also restarts a stretched pulse long enough to light an indicator LED visibly. The next data write loads the lines again.

Top module: `pp_printer_port`

## Requirements
- R1: After reset the data lines are 0, `pr_strobe_n` is 1, `ack_led` is 0 and the status register reads 0 while `pr_busy` is low and `pr_ack_n` is high.
- R2: A write to offset 0xC loads `host_wdata` onto `pr_data` at the next clock edge. Writes to any offset other than 0xC leave `pr_data` unchanged.
- R3: A write to offset 0xD starts a strobe sequence. `pr_strobe_n` stays high for one further clock (setup). It is then low for exactly STROBE_CLKS consecutive cycles and then returns high.
- R4: While a strobe sequence is running (setup or pulse), writes to offset 0xD and to offset 0xC are ignored. The pulse length and `pr_data` are not affected.
- R5: `pr_ack_n` passes through a two-flop synchronizer. A high-to-low transition forces `pr_data` to 0 on the third clock edge after the input falls. Holding the line low produces only one event.
- R6: A data write after an acknowledge clear loads `pr_data` with the new byte. When a data write and an acknowledge event fall on the same edge, the write wins.
- R7: Each acknowledge event raises `ack_led` for exactly LED_CLKS cycles, starting on the same edge that clears the data lines. A further event while it is lit restarts the full count.
- R8: Reading offset 0xB returns a status byte: bit 0 = synchronized busy, bit 1 = acknowledge asserted (synchronized `pr_ack_n` low), bit 2 = strobe sequence running, bits 7:3 = 0. Input changes show up after two clock edges. Reading any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Offset within the port window |
| host_we | input | 1 | Write enable for one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (status at 0xB, 0 elsewhere) |
| pr_data | output | 8 | Printer data lines |
| pr_strobe_n | output | 1 | Active-low strobe to printer |
| pr_busy | input | 1 | Printer busy, active high, asynchronous |
| pr_ack_n | input | 1 | Printer acknowledge, active low, asynchronous |
| ack_led | output | 1 | Stretched acknowledge indicator |

## Verification
The bench builds the port with STROBE_CLKS = 4 and LED_CLKS = 20 in place of the 50-clock strobe and 50 ms stretch. With these values the whole strobe pulse and the whole LED window can be counted edge by edge. A retrigger can also be placed inside the LED window, and the point where the LED would have gone dark without it can be sampled. These short windows also make it cheap to land a data write or a repeat strobe write in the middle of a running sequence, and to line up a write with an acknowledge event on the same edge.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam logic [3:0] OFS_STAT = 4'hB;
  localparam logic [3:0] OFS_DATA = 4'hC;
  localparam logic [3:0] OFS_STRB = 4'hD;

  typedef enum logic [1:0] {SG_IDLE, SG_SETUP, SG_PULSE} sg_state_e;

  // status byte layout: bit0 busy, bit1 ack asserted, bit2 strobe sequence running
  function automatic logic [7:0] pack_status(input logic busy, input logic ack, input logic run);
    return {5'b00000, run, ack, busy};
  endfunction

  // one acknowledge event: synchronized active-low line went from 1 to 0
  function automatic logic fell_edge(input logic prev, input logic now);
    return prev & ~now;
  endfunction
endpackage

// File: rtl/pp_in_sync.sv
module pp_in_sync #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1, s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= INIT;
      s2 <= INIT;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end
  assign q = s2;
endmodule

// File: rtl/pp_strobe_gen.sv
module pp_strobe_gen #(
  parameter int STROBE_CLKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic strobe_n,
  output logic running
);
  import pp_pkg::*;
  localparam int CW = $clog2(STROBE_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STROBE_CLKS - 1);

  sg_state_e st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SG_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        SG_IDLE:  if (start) st <= SG_SETUP;
        SG_SETUP: begin
          st  <= SG_PULSE;
          cnt <= LAST;
        end
        SG_PULSE: begin
          if (cnt == '0) st <= SG_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default:  st <= SG_IDLE;
      endcase
    end
  end

  assign strobe_n = (st != SG_PULSE);
  assign running  = (st != SG_IDLE);
endmodule

// File: rtl/pp_pulse_stretch.sv
module pp_pulse_stretch #(
  parameter int LED_CLKS = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic lit
);
  localparam int CW = $clog2(LED_CLKS + 1);
  localparam logic [CW-1:0] FULL = CW'(LED_CLKS);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (trig)       cnt <= FULL;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
  assign lit = (cnt != '0);
endmodule

// File: rtl/pp_printer_port.sv
module pp_printer_port #(
  parameter int STROBE_CLKS = 50,
  parameter int LED_CLKS    = 2_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] host_addr,
  input  logic       host_we,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic [7:0] pr_data,
  output logic       pr_strobe_n,
  input  logic       pr_busy,
  input  logic       pr_ack_n,
  output logic       ack_led
);
  import pp_pkg::*;

  logic busy_s, ackn_s, ackn_prev;
  logic ack_evt, strb_running, wr_data, wr_strb;
  logic [7:0] data_q;

  pp_in_sync #(.INIT(1'b0)) u_busy (.clk(clk), .rst_n(rst_n), .d(pr_busy),  .q(busy_s));
  pp_in_sync #(.INIT(1'b1)) u_ack  (.clk(clk), .rst_n(rst_n), .d(pr_ack_n), .q(ackn_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ackn_prev <= 1'b1;
    else        ackn_prev <= ackn_s;
  end
  assign ack_evt = fell_edge(ackn_prev, ackn_s);

  assign wr_data = host_we && (host_addr == OFS_DATA) && !strb_running;
  assign wr_strb = host_we && (host_addr == OFS_STRB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (wr_data) data_q <= host_wdata;
    else if (ack_evt) data_q <= '0;
  end
  assign pr_data = data_q;

  pp_strobe_gen #(.STROBE_CLKS(STROBE_CLKS)) u_strb (
    .clk(clk), .rst_n(rst_n), .start(wr_strb),
    .strobe_n(pr_strobe_n), .running(strb_running)
  );

  pp_pulse_stretch #(.LED_CLKS(LED_CLKS)) u_led (
    .clk(clk), .rst_n(rst_n), .trig(ack_evt), .lit(ack_led)
  );

  assign host_rdata = (host_addr == OFS_STAT) ? pack_status(busy_s, ~ackn_s, strb_running) : 8'h00;
endmodule

// File: rtl/pp_printer_port_chk.sv
module pp_printer_port_chk #(
  parameter int STROBE_CLKS = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] host_addr,
  input logic       host_we,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic [7:0] pr_data,
  input logic       pr_strobe_n,
  input logic       ack_evt,
  input logic       strb_running,
  input logic       ack_led
);
  localparam int CW = $clog2(STROBE_CLKS + 2);
  logic [CW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_run <= '0;
    else if (!pr_strobe_n) low_run <= low_run + 1'b1;
    else                   low_run <= '0;
  end

  AST_STROBE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= CW'(STROBE_CLKS)); // R3
  AST_DATA_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pr_strobe_n) && !$past(ack_evt)) |-> $stable(pr_data)); // R3
  AST_WRITE_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == 4'hC && strb_running && !ack_evt) |=> $stable(pr_data)); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && !(host_we && host_addr == 4'hC)) |=> (pr_data == 8'h00)); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == 4'hC && !strb_running) |=> (pr_data == $past(host_wdata))); // R6
  AST_LED_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> ack_led); // R7
  AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[7:3] == 5'b00000); // R8
endmodule

bind pp_printer_port pp_printer_port_chk #(.STROBE_CLKS(STROBE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .pr_data(pr_data),
  .pr_strobe_n(pr_strobe_n), .ack_evt(ack_evt), .strb_running(strb_running),
  .ack_led(ack_led)
);

// File: tb/sim_pp_printer_port.sv
module sim_pp_printer_port;
  localparam int SCL = 4;
  localparam int LCL = 20;
  localparam logic [7:0] VEC [4] = '{8'hA5, 8'hFF, 8'h01, 8'h80};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] host_addr = 4'h0;
  logic host_we = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata, pr_data;
  logic pr_strobe_n, ack_led;
  logic pr_busy = 1'b0;
  logic pr_ack_n = 1'b1;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pp_printer_port #(.STROBE_CLKS(SCL), .LED_CLKS(LCL)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pr_data(pr_data),
    .pr_strobe_n(pr_strobe_n), .pr_busy(pr_busy), .pr_ack_n(pr_ack_n), .ack_led(ack_led)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0; host_addr = 4'h0;
  endtask

  task automatic rd_stat(input string tag, input logic [7:0] exp);
    host_addr = 4'hB; #1;
    chk(tag, host_rdata, exp);
    host_addr = 4'h0;
  endtask

  // strobe write then count low cycles; returns count
  task automatic strobe_len(output int n);
    wr(4'hD, 8'h00);
    chk("R3 setup cycle high", pr_strobe_n, 1);
    n = 0;
    @(negedge clk);
    while (!pr_strobe_n && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_ack(input logic [7:0] old);
    int n;
    pr_ack_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 not yet cleared", pr_data, old);
    @(negedge clk);
    chk("R5 cleared", pr_data, 0);
    n = 0;
    while (ack_led && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R7 led length / R5 single event", n, LCL);
    pr_ack_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 data", pr_data, 0);
    chk("R1 strobe", pr_strobe_n, 1);
    chk("R1 led", ack_led, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_stat("R1 status", 8'h00);

    for (int i = 0; i < 4; i++) begin
      wr(4'hC, VEC[i]);
      chk("R2 R6 data load", pr_data, VEC[i]);
      strobe_len(n);
      chk("R3 strobe length", n, SCL);
      chk("R3 data held", pr_data, VEC[i]);
      do_ack(VEC[i]);
    end

    // R2: other offsets do not touch data
    wr(4'hC, 8'h3C);
    wr(4'h3, 8'h12);
    wr(4'hB, 8'h99);
    chk("R2 other offset ignored", pr_data, 8'h3C);

    // R4: writes during a running sequence
    wr(4'hD, 8'h00);
    rd_stat("R8 running bit", 8'h04);
    wr(4'hC, 8'h55);
    chk("R4 data write ignored in setup", pr_data, 8'h3C);
    wr(4'hD, 8'h00);
    n = 1;
    while (!pr_strobe_n && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R4 pulse length unchanged", n, SCL);
    repeat (3) @(negedge clk);
    chk("R4 no second pulse", pr_strobe_n, 1);
    rd_stat("R8 idle", 8'h00);

    // R8: busy and ack status with sync latency
    pr_busy = 1'b1;
    @(negedge clk);
    rd_stat("R8 busy not yet", 8'h00);
    @(negedge clk);
    rd_stat("R8 busy", 8'h01);
    host_addr = 4'hC; #1;
    chk("R8 other offset reads zero", host_rdata, 0);
    host_addr = 4'h0;
    pr_busy = 1'b0;
    pr_ack_n = 1'b0;
    repeat (2) @(negedge clk);
    rd_stat("R8 ack", 8'h02);
    repeat (LCL + 2) @(negedge clk);
    pr_ack_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6: write on same edge as ack event wins
    wr(4'hC, 8'h11);
    pr_ack_n = 1'b0;
    repeat (2) @(negedge clk);
    wr(4'hC, 8'h77);
    chk("R6 write beats ack", pr_data, 8'h77);
    chk("R7 led lit by event", ack_led, 1);
    repeat (LCL + 2) @(negedge clk);
    pr_ack_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: retrigger restarts the full count
    pr_ack_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 first event", ack_led, 1);
    repeat (5) @(negedge clk);
    pr_ack_n = 1'b1;
    repeat (3) @(negedge clk);
    pr_ack_n = 1'b0;
    repeat (17) @(negedge clk);
    chk("R7 retriggered still lit", ack_led, 1);
    repeat (6) @(negedge clk);
    chk("R7 retriggered ends", ack_led, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule